// File: doc/BRIEF.md
# Tagged Branch Target Buffer

This block sits in the fetch stage and answers, in the same cycle that a fetch address is presented, whether that address is a branch it has seen before and, when it is, where fetch should go next. The answer comes out of stored state, with no decoding of the instruction bits and no address arithmetic on the branch itself. It therefore hands fetch a next PC in a single cycle.

The buffer is direct-mapped. Word-address bits pick a slot, and the remaining address bits form a tag. A stored target is offered only when the slot is valid and its tag equals the fetch address's tag. A slot holding another branch's target is therefore reported as a miss and never as a wrong target. Each slot carries one direction bit.

Slots change only when the execution back end resolves a branch and reports its address, its actual direction and its actual destination. A taken branch claims its slot, evicting whatever was there. A not-taken branch only refreshes a slot it already owns.

Top module: `tagged_btb`

## Requirements
- R1: While reset is asserted and after it is released, every slot is invalid, so every lookup reports hit=0, pred_taken=0 and pred_next_pc = fetch_pc+4 until a taken branch is resolved.
- R2: The slot is selected by fetch_pc[7:2]. The tag is fetch_pc[31:8] together with fetch_pc[1:0]. hit=1 only when the selected slot is valid and its stored tag equals the fetch tag.
- R3: Two addresses with the same bits [7:2] and different tags share one slot. After the second of them is resolved taken, a lookup of the first reports hit=0.
- R4: On a miss, hit=0, pred_taken=0 and pred_next_pc = fetch_pc+4.
- R5: A resolution with res_valid=1 and res_taken=1 writes the slot at res_pc[7:2] with res_pc's tag, direction taken and res_target on the rising edge. From the next cycle, a lookup of res_pc reports hit=1, pred_taken=1 and pred_next_pc = res_target.
- R6: A resolution with res_taken=0 whose res_pc hits its slot clears that slot's direction and stores res_target. A later lookup reports hit=1, pred_taken=0 and pred_next_pc = fetch_pc+4.
- R7: A resolution with res_taken=0 whose res_pc misses leaves the buffer unchanged, including any other branch held in that slot.
- R8: The lookup is combinational from fetch_pc. A resolution in the same cycle, even to the looked-up slot, does not change that cycle's outputs.
- R9: A resolution changes only the slot selected by res_pc[7:2]. Lookups of other slots give the same results before and after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_pc | input | 32 | Address being fetched this cycle |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | 32 | Address of the resolving branch |
| res_taken | input | 1 | Actual direction of the resolving branch |
| res_target | input | 32 | Actual destination of the resolving branch |
| hit | output | 1 | fetch_pc matches a valid slot |
| pred_taken | output | 1 | Hit and the slot predicts taken |
| pred_next_pc | output | 32 | Predicted next fetch address |

## Verification
The bench aims at aliasing between two branches in one slot. A design that compares the index alone would return the other branch's target, and the bench catches this as a false hit. It resolves not-taken branches that miss. A design that allocates on them would hit afterwards, or would evict a taken branch that shares the slot. It sends a resolution to the very slot being looked up in the same cycle. A design that forwards the write would show the new target one cycle early. Random traffic over a small address pool, checked against a bench model, also catches writes that spill into a neighbouring slot and direction bits that are not cleared.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Action taken by the update path for one resolution.
  typedef enum logic [1:0] {
    UPD_NONE    = 2'd0,
    UPD_ALLOC   = 2'd1,
    UPD_REFRESH = 2'd2
  } upd_act_e;

  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned ALIGN_W    = 2;
endpackage

// File: rtl/btb_rst_sync.sv
module btb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/btb_entry.sv
module btb_entry #(
  parameter int unsigned TAG_W = 26,
  parameter int unsigned TGT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TGT_W-1:0] wr_tgt,
  input  logic             wr_dir,
  output logic             valid,
  output logic [TAG_W-1:0] tag,
  output logic [TGT_W-1:0] tgt,
  output logic             dir
);
  logic             valid_q, valid_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic [TGT_W-1:0] tgt_q, tgt_d;
  logic             dir_q, dir_d;

  // Next-state: hold unless written.
  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    tgt_d   = tgt_q;
    dir_d   = dir_q;
    if (wr_en) begin
      valid_d = 1'b1;
      tag_d   = wr_tag;
      tgt_d   = wr_tgt;
      dir_d   = wr_dir;
    end
  end

  // Only the valid bit carries reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid_q <= 1'b0;
    else if (wr_en) valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q <= tag_d;
      tgt_q <= tgt_d;
      dir_q <= dir_d;
    end
  end

  assign valid = valid_q;
  assign tag   = tag_q;
  assign tgt   = tgt_q;
  assign dir   = dir_q;

  // R9: an unwritten slot keeps its contents.
  p_slot_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(valid) && (!valid || ($stable(tag) && $stable(tgt) && $stable(dir)))));

  // R5: a write lands in the next cycle.
  p_slot_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid && tag == $past(wr_tag) && tgt == $past(wr_tgt) && dir == $past(wr_dir)));
endmodule

// File: rtl/btb_update.sv
module btb_update
  import btb_pkg::*;
#(
  parameter int unsigned TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  input  logic             res_taken,
  input  logic [TAG_W-1:0] res_tag,
  input  logic             slot_valid,
  input  logic [TAG_W-1:0] slot_tag,
  output upd_act_e         act,
  output logic             wr_any,
  output logic             wr_dir
);
  logic owns_slot;

  always_comb begin
    owns_slot = slot_valid && (slot_tag == res_tag);
    act       = UPD_NONE;
    if (res_valid) begin
      if (res_taken)      act = UPD_ALLOC;
      else if (owns_slot) act = UPD_REFRESH;
    end
    wr_any = (act != UPD_NONE);
    wr_dir = (act == UPD_ALLOC);
  end

  // R7: a not-taken branch that misses writes nothing.
  p_nt_miss_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_taken && !(slot_valid && slot_tag == res_tag)) |-> !wr_any);

  // R6: a refresh never marks taken.
  p_refresh_nt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_taken) |-> !wr_dir);
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned TAG_W = 26,
  parameter int unsigned STEP  = 4
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [TAG_W-1:0] pc_tag,
  input  logic             slot_valid,
  input  logic [TAG_W-1:0] slot_tag,
  input  logic [PC_W-1:0]  slot_tgt,
  input  logic             slot_dir,
  output logic             hit,
  output logic             taken,
  output logic [PC_W-1:0]  next_pc
);
  logic [PC_W-1:0] seq_pc;

  always_comb begin
    seq_pc  = pc + PC_W'(STEP);
    hit     = slot_valid && (slot_tag == pc_tag);
    taken   = hit && slot_dir;
    next_pc = taken ? slot_tgt : seq_pc;
  end
endmodule

// File: rtl/tagged_btb.sv
module tagged_btb
  import btb_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ENTRIES = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  output logic            hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_next_pc
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned IDX_LO = ALIGN_W;
  localparam int unsigned IDX_HI = IDX_LO + IDX_W - 1;
  localparam int unsigned UP_W = PC_W - IDX_HI - 1;
  localparam int unsigned TAG_W = UP_W + ALIGN_W;

  logic rst_q_n;

  btb_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_q_n)
  );

  // Address split: the tag keeps the upper bits and the alignment bits.
  logic [IDX_W-1:0] f_idx, r_idx;
  logic [TAG_W-1:0] f_tag, r_tag;

  always_comb begin
    f_idx = fetch_pc[IDX_HI:IDX_LO];
    r_idx = res_pc[IDX_HI:IDX_LO];
    f_tag = {fetch_pc[PC_W-1:IDX_HI+1], fetch_pc[ALIGN_W-1:0]};
    r_tag = {res_pc[PC_W-1:IDX_HI+1], res_pc[ALIGN_W-1:0]};
  end

  logic [ENTRIES-1:0] e_valid, e_dir, e_wr;
  logic [TAG_W-1:0]   e_tag [ENTRIES];
  logic [PC_W-1:0]    e_tgt [ENTRIES];
  logic               wr_any, wr_dir;
  upd_act_e           act;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    assign e_wr[i] = wr_any && (r_idx == IDX_W'(i));
    btb_entry #(.TAG_W(TAG_W), .TGT_W(PC_W)) u_entry (
      .clk   (clk),
      .rst_n (rst_q_n),
      .wr_en (e_wr[i]),
      .wr_tag(r_tag),
      .wr_tgt(res_target),
      .wr_dir(wr_dir),
      .valid (e_valid[i]),
      .tag   (e_tag[i]),
      .tgt   (e_tgt[i]),
      .dir   (e_dir[i])
    );
  end

  btb_update #(.TAG_W(TAG_W)) u_upd (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .res_valid (res_valid),
    .res_taken (res_taken),
    .res_tag   (r_tag),
    .slot_valid(e_valid[r_idx]),
    .slot_tag  (e_tag[r_idx]),
    .act       (act),
    .wr_any    (wr_any),
    .wr_dir    (wr_dir)
  );

  btb_lookup #(.PC_W(PC_W), .TAG_W(TAG_W), .STEP(INSN_BYTES)) u_look (
    .pc        (fetch_pc),
    .pc_tag    (f_tag),
    .slot_valid(e_valid[f_idx]),
    .slot_tag  (e_tag[f_idx]),
    .slot_tgt  (e_tgt[f_idx]),
    .slot_dir  (e_dir[f_idx]),
    .hit       (hit),
    .taken     (pred_taken),
    .next_pc   (pred_next_pc)
  );

  // R2: a taken prediction implies a hit.
  p_taken_has_hit_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    pred_taken |-> hit);

  // R4: a miss falls through to the sequential address.
  p_miss_seq_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !hit |-> (!pred_taken && pred_next_pc == fetch_pc + PC_W'(INSN_BYTES)));

  // R5: an allocated branch is predicted taken to its target next cycle.
  p_alloc_seen_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (res_valid && res_taken) |=>
      (fetch_pc != $past(res_pc) || (hit && pred_taken && pred_next_pc == $past(res_target))));

  // R1: nothing hits straight after reset is released.
  p_clean_start_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(rst_q_n) |-> !hit);
endmodule

// File: tb/tagged_btb_test.sv
module tagged_btb_test;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fetch_pc, res_pc, res_target;
  logic        res_valid, res_taken;
  logic        hit, pred_taken;
  logic [31:0] pred_next_pc;

  always #2 clk = ~clk;

  tagged_btb uut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .hit(hit), .pred_taken(pred_taken),
    .pred_next_pc(pred_next_pc)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Bench model
  bit          m_valid [N];
  bit [25:0]   m_tag   [N];
  bit [31:0]   m_tgt   [N];
  bit          m_dir   [N];

  function automatic int idx_of(input logic [31:0] pc);
    return int'(pc[7:2]);
  endfunction

  function automatic bit [25:0] tag_of(input logic [31:0] pc);
    return {pc[31:8], pc[1:0]};
  endfunction

  function automatic bit exp_hit(input logic [31:0] pc);
    return m_valid[idx_of(pc)] && m_tag[idx_of(pc)] == tag_of(pc);
  endfunction

  function automatic bit exp_tk(input logic [31:0] pc);
    return exp_hit(pc) && m_dir[idx_of(pc)];
  endfunction

  function automatic logic [31:0] exp_next(input logic [31:0] pc);
    return exp_tk(pc) ? m_tgt[idx_of(pc)] : pc + 32'd4;
  endfunction

  task automatic model_update(input logic [31:0] pc, input bit tk, input logic [31:0] tgt);
    int i = idx_of(pc);
    if (tk) begin
      m_valid[i] = 1; m_tag[i] = tag_of(pc); m_tgt[i] = tgt; m_dir[i] = 1;
    end else if (exp_hit(pc)) begin
      m_tgt[i] = tgt; m_dir[i] = 0;
    end
  endtask

  task automatic check_look(input string req);
    logic [31:0] en = exp_next(fetch_pc);
    bit eh = exp_hit(fetch_pc);
    bit et = exp_tk(fetch_pc);
    checks++;
    if (hit !== eh || pred_taken !== et || pred_next_pc !== en) begin
      fails++;
      $display("FAIL %s pc=%h got hit=%b tk=%b next=%h exp hit=%b tk=%b next=%h",
               req, fetch_pc, hit, pred_taken, pred_next_pc, eh, et, en);
    end
  endtask

  // One cycle: drive at negedge, check lookup before the edge, update model.
  task automatic step(input logic [31:0] fpc, input bit rv, input logic [31:0] rpc,
                      input bit rt, input logic [31:0] rtg, input string req);
    @(negedge clk);
    fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = rt; res_target = rtg;
    #1;
    check_look(req);
    if (rv) model_update(rpc, rt, rtg);
  endtask

  task automatic look(input logic [31:0] fpc, input string req);
    step(fpc, 0, 32'h0, 0, 32'h0, req);
  endtask

  initial begin : wdog
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  logic [31:0] pool [16];

  initial begin
    for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_dir[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; end
    rst_n = 0; fetch_pc = 32'h1000; res_valid = 0; res_pc = 0; res_taken = 0; res_target = 0;
    repeat (3) @(negedge clk);
    #1 check_look("R1 in reset");
    rst_n = 1;
    repeat (3) @(posedge clk);
    look(32'h0000_1000, "R1 after reset");
    look(32'h0000_10FC, "R1 after reset");

    // R5 allocate then hit
    step(32'h0000_2000, 1, 32'h0000_2040, 1, 32'h0000_3000, "R5 alloc");
    look(32'h0000_2040, "R5 hit taken");
    // R8 same-cycle update to looked-up slot not forwarded
    step(32'h0000_2040, 1, 32'h0000_2040, 1, 32'h0000_4444, "R8 no forward");
    look(32'h0000_2040, "R8 visible after edge");
    // R3 alias: same index, other tag
    look(32'h0001_2040, "R3 alias miss");
    step(32'h0, 1, 32'h0001_2040, 1, 32'h0000_5550, "R3 evict");
    look(32'h0000_2040, "R3 evicted miss");
    look(32'h0001_2040, "R3 new owner hit");
    // R2 misaligned address does not hit
    look(32'h0001_2042, "R2 align bits in tag");
    // R7 not-taken miss leaves owner intact
    step(32'h0, 1, 32'h0000_2040, 0, 32'h0000_9990, "R7 nt miss");
    look(32'h0001_2040, "R7 owner kept");
    look(32'h0000_2040, "R7 no alloc");
    // R6 not-taken hit clears direction
    step(32'h0, 1, 32'h0001_2040, 0, 32'h0000_7770, "R6 nt hit");
    look(32'h0001_2040, "R6 hit not taken");
    // R9 neighbour untouched
    step(32'h0, 1, 32'h0000_0080, 1, 32'h0000_0100, "R9 setup");
    step(32'h0, 1, 32'h0000_0084, 1, 32'h0000_0200, "R9 write neighbour");
    look(32'h0000_0080, "R9 neighbour intact");
    look(32'h0000_0084, "R9 neighbour written");

    // Random traffic over a small pool with shared indices
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++)
      pool[i] = {($urandom() % 4) << 8} | ((($urandom() % 4) << 2)) | 32'h0040_0000;
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] f = pool[$urandom() % 16];
      logic [31:0] r = pool[$urandom() % 16];
      bit rv = ($urandom() % 3) == 0;
      bit rt = $urandom() % 2;
      logic [31:0] tg = $urandom() & 32'hFFFF_FFFC;
      step(f, rv, r, rt, tg, "R4 R5 R6 R7 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule